// File: doc/BRIEF.md
# Polyphase Interpolating FIR Filter

This block raises the sample rate of a complex baseband stream by an integer factor L and filters it in the same step. Seen from outside, it acts as though L-1 zeros were stuffed after every input sample and an N-tap FIR then ran at the raised rate. Inside, it never multiplies by a stuffed zero. Each output phase p uses only the taps h[p], h[p+L], h[p+2L] and so on, applied to the newest input and the inputs before it. This cuts both the multiply count per output and the history depth by about L.

Software writes the coefficients through a write port, grouped by phase: tap h[n] goes to address p*T + k, where p = n mod L, k = n div L and T = ceil(N/L). One sequential multiply-accumulate datapath, duplicated for the real and imaginary lanes, works through the taps of one phase per request. The consumer pulls outputs with a request strobe. A new input is taken only after all L phases of the current input have been delivered.

Top module: `poly_interp_fir`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0 and both output words are 0.
- R2: An input is taken on a rising edge where in_valid_i and in_ready_o are both 1. in_ready_o then stays 0 until the L-th output for that input. It returns to 1 in the same cycle in which that L-th out_valid_o is high.
- R3: The output of phase p (counted 0 to L-1 after each input) is sum over k of h[p+kL]*x[m-k] for all k with p+kL < N. Here x[m] is the newest input, and h[p+kL] is read from coefficient address p*ceil(N/L)+k. The sum is then rounded and saturated as in R6 and R7. Coefficients are 16-bit two's complement.
- R4: The real and imaginary lanes use the same coefficients, and each lane is computed only from its own input words.
- R5: Inputs not yet received since reset count as zero in the R3 sum.
- R6: The sum is rounded by adding 2^14 and shifting right arithmetically by 15 bits. Ties therefore round toward plus infinity.
- R7: A rounded result outside -32768..32767 is clamped to the nearest of those two limits.
- R8: out_req_i has no effect while in_ready_o is 1, and in_valid_i has no effect while in_ready_o is 0.
- R9: Let C be the number of taps of a phase. Counting the rising edge that samples out_req_i as edge 1, out_valid_o is high for exactly one cycle, following edge C+2.
- R10: Between out_valid_o pulses, out_re_o and out_im_o hold the last output.
- R11: A phase with p >= N has no taps. It produces 0 after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_m1_i | input | 7 | Interpolation factor minus one (L-1) |
| n_m1_i | input | 7 | Filter length minus one (N-1) |
| cw_en_i | input | 1 | Coefficient write strobe |
| cw_addr_i | input | 8 | Coefficient address, phase*ceil(N/L)+tap |
| cw_data_i | input | 16 | Coefficient, signed |
| in_valid_i | input | 1 | Input sample offered |
| in_re_i | input | 16 | Input real word, signed |
| in_im_i | input | 16 | Input imaginary word, signed |
| in_ready_o | output | 1 | Block waits for a new input |
| out_req_i | input | 1 | Request for the next output phase |
| out_valid_o | output | 1 | Output word pair updated this cycle |
| out_re_o | output | 16 | Output real word, signed |
| out_im_o | output | 16 | Output imaginary word, signed |

## Verification
The bench runs the filter over a set of (L, N) pairs: L=1, L below N with N a multiple of L, N not a multiple of L, L larger than N, and a wide L=99/N=100 case. This separates phase-indexing and address-stride errors from plain tap-order errors, and it exercises empty phases. The real and imaginary streams are driven from different sequences, so a lane mix-up or a shared accumulator shows up as a mismatch. Short runs right after reset test the zero-filled history. Literal corner patterns test the rounding tie, a negative value just below a tie, and saturation at both limits. The measured request-to-valid latency is compared with the per-phase tap count, which shows that no multiply is spent on stuffed zeros.

// File: rtl/poly_fir_pkg.sv
package poly_fir_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_IN  = 2'd0,
    ST_WAIT_REQ = 2'd1,
    ST_MAC      = 2'd2,
    ST_OUT      = 2'd3
  } fir_state_e;
endpackage

// File: rtl/poly_coef_mem.sv
module poly_coef_mem #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned COEF_W = 16,
  localparam int unsigned A_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [A_W-1:0]    waddr_i,
  input  logic [COEF_W-1:0] wdata_i,
  input  logic [A_W-1:0]    raddr_i,
  output logic [COEF_W-1:0] rdata_o
);
  logic [COEF_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/poly_hist_mem.sv
module poly_hist_mem #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 32,
  localparam int unsigned A_W  = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [A_W-1:0] waddr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic [A_W-1:0] raddr_i,
  output logic [W-1:0]   rdata_o
);
  // no reset: entries beyond the fill level are masked by the controller
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/poly_mac_lane.sv
module poly_mac_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ACC_W  = 39,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              term_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [COEF_W-1:0] h_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned P_W = DATA_W + COEF_W;
  localparam int unsigned T_W = ACC_W - DATA_W + 2;

  logic signed [P_W-1:0]   prod;
  logic        [ACC_W-1:0] prod_ext;
  logic        [ACC_W-1:0] acc_q;
  logic signed [ACC_W:0]   rnd;
  logic signed [ACC_W:0]   shr;
  logic        [T_W-1:0]   top_bits;
  logic                    ovf;
  logic        [DATA_W-1:0] sat;
  logic        [DATA_W-1:0] res_q;

  assign prod     = $signed(x_i) * $signed(h_i);
  assign prod_ext = {{(ACC_W-P_W){prod[P_W-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (clr_i)             acc_q <= '0;
    else if (step_i && term_i)  acc_q <= acc_q + prod_ext;
  end

  // round half up, then clamp to DATA_W
  assign rnd      = $signed({acc_q[ACC_W-1], acc_q})
                  + $signed({{(ACC_W+1-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}});
  assign shr      = rnd >>> FRAC_W;
  assign top_bits = shr[ACC_W:DATA_W-1];
  assign ovf      = !((&top_bits) || (~|top_bits));
  assign sat      = !ovf ? shr[DATA_W-1:0]
                  : (shr[ACC_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= sat;
  end

  assign res_o = res_q;
endmodule

// File: rtl/poly_ctrl.sv
module poly_ctrl
  import poly_fir_pkg::*;
#(
  parameter int unsigned MAX_N = 128,
  parameter int unsigned N_W   = 7,
  parameter int unsigned L_W   = 7,
  parameter int unsigned CA_W  = 8,
  parameter int unsigned HA_W  = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [L_W-1:0]  l_m1_i,
  input  logic [N_W-1:0]  n_m1_i,
  input  logic            in_valid_i,
  input  logic            out_req_i,
  output logic            in_ready_o,
  output logic            hist_we_o,
  output logic [HA_W-1:0] hist_waddr_o,
  output logic [HA_W-1:0] hist_raddr_o,
  output logic [CA_W-1:0] coef_raddr_o,
  output logic            acc_clr_o,
  output logic            step_o,
  output logic            term_o,
  output logic            load_o
);
  localparam int unsigned S_W = ((N_W > L_W) ? N_W : L_W) + 2;
  localparam logic [N_W:0] FILL_MAX = (N_W+1)'(MAX_N);

  fir_state_e      st_q;
  logic [L_W-1:0]  phase_q;
  logic [CA_W:0]   base_q;
  logic [N_W:0]    k_q;
  logic [S_W-1:0]  idx_q;
  logic [HA_W-1:0] newest_q;
  logic [N_W:0]    fill_q;

  logic [S_W-1:0]  len_l, len_n, taps, idx_nxt;
  logic [CA_W:0]   caddr_full;
  logic            has_taps;

  assign len_l    = S_W'(l_m1_i) + S_W'(1);
  assign len_n    = S_W'(n_m1_i) + S_W'(1);
  assign taps     = (len_n + len_l - S_W'(1)) / len_l;  // taps per phase, ceil(N/L)
  assign idx_nxt  = idx_q + len_l;
  assign has_taps = S_W'(phase_q) < len_n;

  assign caddr_full   = base_q + (CA_W+1)'(k_q);
  assign coef_raddr_o = caddr_full[CA_W-1:0];
  assign hist_raddr_o = newest_q - HA_W'(k_q);
  assign hist_waddr_o = newest_q + HA_W'(1);

  assign in_ready_o = (st_q == ST_WAIT_IN);
  assign hist_we_o  = in_ready_o && in_valid_i;
  assign acc_clr_o  = (st_q == ST_WAIT_REQ) && out_req_i;
  assign step_o     = (st_q == ST_MAC);
  assign term_o     = k_q < fill_q;
  assign load_o     = (st_q == ST_OUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_WAIT_IN;
      phase_q  <= '0;
      base_q   <= '0;
      k_q      <= '0;
      idx_q    <= '0;
      newest_q <= '1;
      fill_q   <= '0;
    end else begin
      case (st_q)
        ST_WAIT_IN: if (in_valid_i) begin
          newest_q <= newest_q + HA_W'(1);
          if (fill_q != FILL_MAX) fill_q <= fill_q + (N_W+1)'(1);
          phase_q  <= '0;
          base_q   <= '0;
          st_q     <= ST_WAIT_REQ;
        end
        ST_WAIT_REQ: if (out_req_i) begin
          k_q   <= '0;
          idx_q <= S_W'(phase_q);
          st_q  <= has_taps ? ST_MAC : ST_OUT;
        end
        ST_MAC: begin
          k_q   <= k_q + (N_W+1)'(1);
          idx_q <= idx_nxt;
          if (idx_nxt >= len_n) st_q <= ST_OUT;
        end
        ST_OUT: begin
          if (phase_q == l_m1_i) begin
            st_q <= ST_WAIT_IN;
          end else begin
            phase_q <= phase_q + L_W'(1);
            base_q  <= base_q + (CA_W+1)'(taps);
            st_q    <= ST_WAIT_REQ;
          end
        end
        default: st_q <= ST_WAIT_IN;
      endcase
    end
  end
endmodule

// File: rtl/poly_interp_fir.sv
module poly_interp_fir #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned MAX_N  = 128,
  parameter int unsigned MAX_L  = 128,
  parameter int unsigned FRAC_W = 15,
  localparam int unsigned N_W   = $clog2(MAX_N),
  localparam int unsigned L_W   = $clog2(MAX_L),
  localparam int unsigned CA_W  = $clog2(MAX_N + MAX_L)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [L_W-1:0]    l_m1_i,
  input  logic [N_W-1:0]    n_m1_i,
  input  logic              cw_en_i,
  input  logic [CA_W-1:0]   cw_addr_i,
  input  logic [COEF_W-1:0] cw_data_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_re_i,
  input  logic [DATA_W-1:0] in_im_i,
  output logic              in_ready_o,
  input  logic              out_req_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_re_o,
  output logic [DATA_W-1:0] out_im_o
);
  localparam int unsigned HA_W   = $clog2(MAX_N);
  localparam int unsigned HIST_D = 1 << HA_W;
  localparam int unsigned COEF_D = 1 << CA_W;
  localparam int unsigned ACC_W  = DATA_W + COEF_W + $clog2(MAX_N);
  localparam int unsigned LANES  = 2;

  logic              hist_we, acc_clr, step, term, load;
  logic [HA_W-1:0]   hist_waddr, hist_raddr;
  logic [CA_W-1:0]   coef_raddr;
  logic [COEF_W-1:0] coef;
  logic [LANES*DATA_W-1:0] hist_rdata;
  logic [DATA_W-1:0] lane_res [LANES];
  logic              out_valid_q;

  poly_ctrl #(
    .MAX_N(MAX_N), .N_W(N_W), .L_W(L_W), .CA_W(CA_W), .HA_W(HA_W)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .l_m1_i       (l_m1_i),
    .n_m1_i       (n_m1_i),
    .in_valid_i   (in_valid_i),
    .out_req_i    (out_req_i),
    .in_ready_o   (in_ready_o),
    .hist_we_o    (hist_we),
    .hist_waddr_o (hist_waddr),
    .hist_raddr_o (hist_raddr),
    .coef_raddr_o (coef_raddr),
    .acc_clr_o    (acc_clr),
    .step_o       (step),
    .term_o       (term),
    .load_o       (load)
  );

  poly_coef_mem #(.DEPTH(COEF_D), .COEF_W(COEF_W)) i_coef (
    .clk_i   (clk_i),
    .we_i    (cw_en_i),
    .waddr_i (cw_addr_i),
    .wdata_i (cw_data_i),
    .raddr_i (coef_raddr),
    .rdata_o (coef)
  );

  poly_hist_mem #(.DEPTH(HIST_D), .W(LANES*DATA_W)) i_hist (
    .clk_i   (clk_i),
    .we_i    (hist_we),
    .waddr_i (hist_waddr),
    .wdata_i ({in_im_i, in_re_i}),
    .raddr_i (hist_raddr),
    .rdata_o (hist_rdata)
  );

  // lane 0 real, lane 1 imaginary; shared coefficient
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    poly_mac_lane #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)
    ) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (acc_clr),
      .step_i (step),
      .term_i (term),
      .load_i (load),
      .x_i    (hist_rdata[g*DATA_W +: DATA_W]),
      .h_i    (coef),
      .res_o  (lane_res[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_q <= 1'b0;
    else         out_valid_q <= load;
  end

  assign out_valid_o = out_valid_q;
  assign out_re_o    = lane_res[0];
  assign out_im_o    = lane_res[1];
endmodule

// File: rtl/poly_interp_fir_chk.sv
module poly_interp_fir_chk #(
  parameter int unsigned L_W    = 7,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [L_W-1:0]    l_m1_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_req_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_re_o,
  input logic [DATA_W-1:0] out_im_o
);
  logic [L_W:0] out_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      out_cnt_q <= '0;
    else if (in_ready_o && in_valid_i) out_cnt_q <= '0;
    else if (out_valid_o)             out_cnt_q <= out_cnt_q + (L_W+1)'(1);
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && in_valid_i |=> !in_ready_o);

  assert_wait_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> in_ready_o);

  assert_phase_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> (out_cnt_q + (L_W+1)'(out_valid_o)) == ((L_W+1)'(l_m1_i) + (L_W+1)'(1)));

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_req_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && out_req_i |=> !out_valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_re_o) && $stable(out_im_o));
endmodule

bind poly_interp_fir poly_interp_fir_chk #(.L_W(L_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .l_m1_i      (l_m1_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_req_i   (out_req_i),
  .out_valid_o (out_valid_o),
  .out_re_o    (out_re_o),
  .out_im_o    (out_im_o)
);

// File: tb/test_poly_interp_fir.sv
`timescale 1ns/1ps
module test_poly_interp_fir;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  l_m1 = '0, n_m1 = '0;
  logic        cw_en = 1'b0;
  logic [7:0]  cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_re = '0, in_im = '0;
  logic        out_req = 1'b0;
  logic        in_ready, out_valid;
  logic [15:0] out_re, out_im;

  int errors = 0;
  int checks = 0;
  int h [256];
  int xr [128];
  int xi [128];
  int bfill, cl, cn;

  always #2.5 clk = ~clk;

  poly_interp_fir i_poly_interp_fir (
    .clk_i(clk), .rst_ni(rst_n), .l_m1_i(l_m1), .n_m1_i(n_m1),
    .cw_en_i(cw_en), .cw_addr_i(cw_addr), .cw_data_i(cw_data),
    .in_valid_i(in_valid), .in_re_i(in_re), .in_im_i(in_im), .in_ready_o(in_ready),
    .out_req_i(out_req), .out_valid_o(out_valid), .out_re_o(out_re), .out_im_o(out_im)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bfill = 0;
    for (int i = 0; i < 128; i++) begin xr[i] = 0; xi[i] = 0; end
    @(negedge clk);
  endtask

  task automatic set_cfg(input int l, input int n);
    cl = l; cn = n;
    l_m1 = 7'(l - 1);
    n_m1 = 7'(n - 1);
  endtask

  task automatic write_tap(input int n, input int val);
    int t;
    t = (cn + cl - 1) / cl;
    h[n] = val;
    @(negedge clk);
    cw_en = 1'b1;
    cw_addr = 8'((n % cl) * t + n / cl);
    cw_data = 16'(val);
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic load_taps(input int seed);
    for (int n = 0; n < cn; n++) write_tap(n, ((n * 2749 + seed * 101) % 16384) - 8192);
  endtask

  task automatic push(input int re, input int im);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_re = 16'(re);
    in_im = 16'(im);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 127; i > 0; i--) begin xr[i] = xr[i-1]; xi[i] = xi[i-1]; end
    xr[0] = re; xi[0] = im;
    if (bfill < 128) bfill++;
  endtask

  function automatic int model(input int p, input bit im);
    longint acc = 0;
    for (int k = 0; p + k * cl < cn; k++)
      if (k < bfill) acc += longint'(h[p + k * cl]) * longint'(im ? xi[k] : xr[k]);
    acc = (acc + 16384) >>> 15;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic int tap_cnt(input int p);
    int c = 0;
    for (int k = 0; p + k * cl < cn; k++) c++;
    return c;
  endfunction

  // request one output; returns edges to valid
  task automatic pull(output int n);
    @(negedge clk);
    out_req = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    out_req = 1'b0;
    while (!out_valid && n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_input(input int re, input int im);
    int n;
    bit short_hist;
    push(re, im);
    for (int p = 0; p < cl; p++) begin
      short_hist = bfill < (cn + cl - 1) / cl;
      pull(n);
      check(tap_cnt(p) == 0 ? "R11 latency" : "R9 latency", n, tap_cnt(p) + 2);
      check(short_hist ? "R5 re" : "R3 re", longint'($signed(out_re)), model(p, 1'b0));
      check("R4 im", longint'($signed(out_im)), model(p, 1'b1));
      check("R2 ready", in_ready, p == cl - 1);
    end
  endtask

  task automatic sweep(input int l, input int n, input int seed, input int count);
    do_reset();
    set_cfg(l, n);
    load_taps(seed);
    for (int i = 0; i < count; i++)
      run_input(((i * 12345 + seed * 6789) % 65536) - 32768,
                ((i * 23451 + seed * 971 + 777) % 65536) - 32768);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int hold_re, hold_im;
    do_reset();
    check("R1 ready", in_ready, 1);
    check("R1 valid", out_valid, 0);
    check("R1 re", out_re, 0);
    check("R1 im", out_im, 0);

    // R8: requests while waiting for input
    set_cfg(3, 7);
    load_taps(3);
    @(negedge clk);
    out_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 req ignored valid", out_valid, 0);
      check("R8 req ignored ready", in_ready, 1);
    end
    out_req = 1'b0;

    // R8: input offered while busy
    push(1000, -2000);
    @(negedge clk);
    in_valid = 1'b1; in_re = 16'(12345); in_im = 16'(-321);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    check("R8 input ignored ready", in_ready, 0);
    for (int p = 0; p < cl; p++) begin
      pull(n);
      check("R8 re after ignored input", longint'($signed(out_re)), model(p, 1'b0));
      check("R8 im after ignored input", longint'($signed(out_im)), model(p, 1'b1));
    end

    // R10: hold without new requests
    hold_re = $signed(out_re);
    hold_im = $signed(out_im);
    repeat (5) @(negedge clk);
    check("R10 re hold", longint'($signed(out_re)), hold_re);
    check("R10 im hold", longint'($signed(out_im)), hold_im);

    sweep(1, 4, 1, 6);
    sweep(3, 7, 2, 5);
    sweep(4, 12, 4, 5);
    sweep(5, 3, 5, 3);
    sweep(2, 16, 6, 10);
    sweep(99, 100, 7, 2);

    // R6 rounding corners: h = {1, 0}
    do_reset();
    set_cfg(1, 2);
    write_tap(0, 1);
    write_tap(1, 0);
    push(16384, -16384);
    pull(n);
    check("R6 tie up", longint'($signed(out_re)), 1);
    check("R6 neg tie", longint'($signed(out_im)), 0);
    push(16383, -16385);
    pull(n);
    check("R6 below tie", longint'($signed(out_re)), 0);
    check("R6 neg below tie", longint'($signed(out_im)), -1);

    // R7 saturation: h = {32767, 32767}
    do_reset();
    set_cfg(1, 2);
    write_tap(0, 32767);
    write_tap(1, 32767);
    push(32767, -32768);
    pull(n);
    check("R7 re in range", longint'($signed(out_re)), 32766);
    check("R7 im in range", longint'($signed(out_im)), -32767);
    push(32767, -32768);
    pull(n);
    check("R7 re clamp high", longint'($signed(out_re)), 32767);
    check("R7 im clamp low", longint'($signed(out_im)), -32768);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule